// File: doc/BRIEF.md
# I/O Window Address Translator

This block connects a processor's 8 MB memory-mapped I/O aperture to a 16-bit port-addressed I/O bus. Decoding of the aperture base is done upstream, so the block receives only the 23-bit offset inside the aperture. It also receives an access size (byte, halfword or word), a write flag and write data. From these it forms a port address and presents the access to the I/O side over a request/acknowledge handshake.

Two address maps are supported, and an internal map-select bit chooses between them. In the contiguous map, the port address is the low 16 bits of the offset. In the sparse map, the port address is built from two separated fields of the offset, so that every group of 32 ports lands on its own 4 KB page of the aperture.

When the big-endian view is enabled, multi-byte accesses have their byte lanes reversed in both directions. Only one access is in flight at a time. The processor sees ready drop while the access is pending, and read data is captured on the acknowledge.

Top module: `iowin_xlate`

## Requirements
- R1: After reset `cpu_ready` is 1, `io_req` is 0, `cpu_rdata` is 0 and the map-select bit is 0 (contiguous).
- R2: With map-select 0, `io_addr` equals `cpu_ofs[15:0]` as sampled at acceptance.
- R3: With map-select 1, `io_addr[4:0]` equals `cpu_ofs[4:0]` and `io_addr[15:5]` equals `cpu_ofs[22:12]`; offset bits 11..5 are discarded.
- R4: Size code 2'b00 (byte) passes lane 0 through unswapped in both directions, and lanes 1..3 read as zero.
- R5: Size code 2'b01 (halfword) with `be_swap`=1 exchanges bytes 0 and 1 of write and read data, and bits 31..16 read as zero.
- R6: Size code 2'b10 (word) with `be_swap`=1 reverses all four bytes of write and read data.
- R7: With `be_swap`=0, halfword and word data pass unswapped, and lanes above the access size read as zero.
- R8: Read data is taken from `io_rdata` on the cycle `io_ack` is high, converted by the size and swap rules, and is visible on `cpu_rdata` when `cpu_ready` returns.
- R9: An access is accepted when `cpu_req` and `cpu_ready` are both high. On the next cycle `io_req` is 1 and `cpu_ready` is 0. Both hold until the cycle after `io_ack`, when `cpu_ready` is 1 and `io_req` is 0.
- R10: `cpu_req` while an access is pending is ignored: `io_addr`, `io_wdata`, `io_size` and `io_we` stay unchanged until the acknowledge.
- R11: `io_size` and `io_we` carry the size code and write flag sampled at acceptance.
- R12: `map_wr` loads `map_sparse_d` into the map-select bit at any time. The map-select bit and `be_swap` are sampled at acceptance, so changing either during a pending access changes neither that access's address nor its data conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_wr | input | 1 | Load strobe for the map-select bit |
| map_sparse_d | input | 1 | New map-select value (1 = sparse) |
| be_swap | input | 1 | Enable big-endian lane reversal |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Write (1) or read (0) |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10 word |
| cpu_ofs | input | 23 | Offset inside the I/O aperture |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ready | output | 1 | Idle, able to accept an access |
| cpu_rdata | output | 32 | Read data of the last completed access |
| io_req | output | 1 | Pending I/O access |
| io_we | output | 1 | I/O write flag |
| io_size | output | 2 | I/O access size code |
| io_addr | output | 16 | I/O port address |
| io_wdata | output | 32 | Lane-converted write data |
| io_ack | input | 1 | I/O completion strobe |
| io_rdata | input | 32 | I/O read data, valid with `io_ack` |

## Verification
The handshake assertions assume that the I/O side raises `io_ack` only while `io_req` is high, and that `io_ack` lasts a single cycle. The bench's responder pulses the acknowledge once per access and only after it has seen the request. The responder waits a random delay of zero to several cycles before doing so.

The size code 2'b11 is assumed never to be issued, so random sizes are drawn from the three legal codes only. During a pending access the bench keeps `cpu_req` high with a different offset. It also flips `be_swap` and the map-select bit mid-flight, which exercises the ignore and sampling rules without breaking those assumptions.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10
   } acc_size_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } txn_state_e;

   // number of byte lanes covered by a size code (word and reserved = all lanes)
   function automatic int unsigned lanes_of(input logic [1:0] sz, input int unsigned all_lanes);
      case (sz)
         SZ_BYTE: lanes_of = 1;
         SZ_HALF: lanes_of = (all_lanes < 2) ? all_lanes : 2;
         default: lanes_of = all_lanes;
      endcase
   endfunction
endpackage

// File: rtl/iowin_portmap.sv
module iowin_portmap #(
   parameter int OFS_W   = 23,
   parameter int PORT_W  = 16,
   parameter int LO_BITS = 5,
   parameter int HI_LSB  = 12
) (
   input  logic [OFS_W-1:0]  ofs,
   input  logic              sparse,
   output logic [PORT_W-1:0] port
);
   localparam int HI_W = PORT_W - LO_BITS;

   if (PORT_W > OFS_W) begin : g_bad_w
      $error("iowin_portmap: PORT_W must not exceed OFS_W");
   end
   if (HI_LSB + HI_W > OFS_W) begin : g_bad_hi
      $error("iowin_portmap: sparse high field overruns the offset");
   end
   if (LO_BITS >= PORT_W || LO_BITS > HI_LSB) begin : g_bad_lo
      $error("iowin_portmap: low field must be narrower than the port and below the high field");
   end

   logic [PORT_W-1:0] contig_addr;
   logic [PORT_W-1:0] sparse_addr;

   assign contig_addr = ofs[PORT_W-1:0];
   assign sparse_addr = {ofs[HI_LSB +: HI_W], ofs[LO_BITS-1:0]};
   assign port        = sparse ? sparse_addr : contig_addr;
endmodule

// File: rtl/iowin_laneswap.sv
module iowin_laneswap
   import iowin_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [1:0]        size,
   input  logic              swap,
   output logic [DATA_W-1:0] dout
);
   localparam int LANES = DATA_W / 8;
   localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

   if (DATA_W % 8 != 0 || LANES < 1) begin : g_bad_w
      $error("iowin_laneswap: DATA_W must be a positive multiple of 8");
   end

   int unsigned active;
   assign active = lanes_of(size, LANES);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LIDX_W-1:0] src;
      if (SWAP_SUPPORT) begin : g_sw
         always_comb begin
            if (swap && (i < active)) src = LIDX_W'(active - 1 - i);
            else                      src = LIDX_W'(i);
         end
      end else begin : g_nosw
         assign src = LIDX_W'(i);
      end
      always_comb begin
         if (i < active) dout[8*i +: 8] = din[8*src +: 8];
         else            dout[8*i +: 8] = 8'h00;
      end
   end
endmodule

// File: rtl/iowin_txn_ctl.sv
module iowin_txn_ctl
   import iowin_pkg::*;
#(
   parameter int PORT_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_size,
   input  logic              swap_in,
   input  logic [PORT_W-1:0] port_in,
   input  logic [DATA_W-1:0] wdata_cv,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              io_req,
   output logic              io_we,
   output logic [1:0]        io_size,
   output logic [PORT_W-1:0] io_addr,
   output logic [DATA_W-1:0] io_wdata,
   output logic              held_swap,
   input  logic              io_ack,
   input  logic [DATA_W-1:0] rdata_cv
);
   txn_state_e state_q;
   logic       accept;

   assign cpu_ready = (state_q == ST_IDLE);
   assign accept    = cpu_ready && cpu_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         io_req    <= 1'b0;
         io_we     <= 1'b0;
         io_size   <= SZ_BYTE;
         io_addr   <= '0;
         io_wdata  <= '0;
         held_swap <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q   <= ST_BUSY;
                  io_req    <= 1'b1;
                  io_we     <= cpu_we;
                  io_size   <= cpu_size;
                  io_addr   <= port_in;
                  io_wdata  <= wdata_cv;
                  held_swap <= swap_in;
               end
            end
            default: begin
               if (io_ack) begin
                  state_q   <= ST_IDLE;
                  io_req    <= 1'b0;
                  cpu_rdata <= rdata_cv;
               end
            end
         endcase
      end
   end

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_req && !io_ack |=> io_req && !cpu_ready);
   // R9
   req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_req |-> !cpu_ready);
   // R9
   ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_req && io_ack |=> cpu_ready && !io_req);
   // R9
   accept_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_ready |=> io_req);
   // R10
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_req && !io_ack |=> $stable(io_addr) && $stable(io_wdata) && $stable(io_size) && $stable(io_we));
   // R8
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready && !io_req && !(io_ack) |=> $stable(cpu_rdata));
endmodule

// File: rtl/iowin_xlate.sv
module iowin_xlate
   import iowin_pkg::*;
#(
   parameter int OFS_W        = 23,
   parameter int PORT_W       = 16,
   parameter int DATA_W       = 32,
   parameter int LO_BITS      = 5,
   parameter int HI_LSB       = 12,
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              map_wr,
   input  logic              map_sparse_d,
   input  logic              be_swap,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_size,
   input  logic [OFS_W-1:0]  cpu_ofs,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              io_req,
   output logic              io_we,
   output logic [1:0]        io_size,
   output logic [PORT_W-1:0] io_addr,
   output logic [DATA_W-1:0] io_wdata,
   input  logic              io_ack,
   input  logic [DATA_W-1:0] io_rdata
);
   logic              map_sparse_q;
   logic [PORT_W-1:0] port_nxt;
   logic [DATA_W-1:0] wdata_cv;
   logic [DATA_W-1:0] rdata_cv;
   logic              held_swap;

   always_ff @(posedge clk) begin
      if (!rst_n)      map_sparse_q <= 1'b0;
      else if (map_wr) map_sparse_q <= map_sparse_d;
   end

   iowin_portmap #(
      .OFS_W(OFS_W), .PORT_W(PORT_W), .LO_BITS(LO_BITS), .HI_LSB(HI_LSB)
   ) u_map (
      .ofs(cpu_ofs), .sparse(map_sparse_q), .port(port_nxt)
   );

   iowin_laneswap #(.DATA_W(DATA_W), .SWAP_SUPPORT(SWAP_SUPPORT)) u_wswap (
      .din(cpu_wdata), .size(cpu_size), .swap(be_swap), .dout(wdata_cv)
   );

   iowin_laneswap #(.DATA_W(DATA_W), .SWAP_SUPPORT(SWAP_SUPPORT)) u_rswap (
      .din(io_rdata), .size(io_size), .swap(held_swap), .dout(rdata_cv)
   );

   iowin_txn_ctl #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
      .swap_in(be_swap), .port_in(port_nxt), .wdata_cv(wdata_cv),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .io_req(io_req), .io_we(io_we), .io_size(io_size),
      .io_addr(io_addr), .io_wdata(io_wdata), .held_swap(held_swap),
      .io_ack(io_ack), .rdata_cv(rdata_cv)
   );

   // R11
   size_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_ready |=> io_size == $past(cpu_size) && io_we == $past(cpu_we));
   // R2
   contig_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_ready && !map_sparse_q |=> io_addr == $past(cpu_ofs[PORT_W-1:0]));
   // R4
   byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_req && io_size == SZ_BYTE |-> io_wdata[DATA_W-1:8] == '0);
endmodule

// File: tb/iowin_xlate_tb.sv
module iowin_xlate_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        map_wr = 1'b0, map_sparse_d = 1'b0, be_swap = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [1:0]  cpu_size = 2'b00;
   logic [22:0] cpu_ofs = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        io_req, io_we;
   logic [1:0]  io_size;
   logic [15:0] io_addr;
   logic [31:0] io_wdata;
   logic        io_ack = 1'b0;
   logic [31:0] io_rdata = '0;

   int n_chk = 0, n_fail = 0;
   logic mode_m = 1'b0;

   always #5 clk = ~clk;

   iowin_xlate dut_i (
      .clk(clk), .rst_n(rst_n), .map_wr(map_wr), .map_sparse_d(map_sparse_d),
      .be_swap(be_swap), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
      .cpu_ofs(cpu_ofs), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
      .cpu_rdata(cpu_rdata), .io_req(io_req), .io_we(io_we), .io_size(io_size),
      .io_addr(io_addr), .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] conv(input logic [31:0] d, input logic [1:0] sz, input logic sw);
      case (sz)
         2'b00:   conv = {24'h0, d[7:0]};
         2'b01:   conv = sw ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
         default: conv = sw ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
      endcase
   endfunction

   function automatic string dtag(input logic [1:0] sz, input logic sw);
      if (sz == 2'b00) dtag = "R4";
      else if (!sw)    dtag = "R7";
      else if (sz == 2'b01) dtag = "R5";
      else             dtag = "R6";
   endfunction

   task automatic run_txn(input logic [22:0] ofs, input logic [1:0] sz, input logic we,
                          input logic [31:0] wd, input logic [31:0] rd, input int dly, input bit poke);
      logic        sw, sp;
      logic [15:0] ea;
      logic [31:0] ew;
      sw = be_swap;
      sp = mode_m;
      ea = sp ? {ofs[22:12], ofs[4:0]} : ofs[15:0];
      ew = conv(wd, sz, sw);
      cpu_req = 1'b1; cpu_ofs = ofs; cpu_size = sz; cpu_we = we; cpu_wdata = wd;
      @(posedge clk); @(negedge clk);
      chk(io_req == 1'b1 && cpu_ready == 1'b0, "R9", {30'h0, io_req, cpu_ready}, 32'h2);
      chk(io_addr == ea, sp ? "R3" : "R2", {16'h0, io_addr}, {16'h0, ea});
      chk(io_wdata == ew, dtag(sz, sw), io_wdata, ew);
      chk(io_size == sz && io_we == we, "R11", {29'h0, io_we, io_size}, {29'h0, we, sz});
      // R10: a request held high during the pending access must be ignored
      cpu_ofs = ofs ^ 23'h7fffff;
      cpu_wdata = ~wd;
      cpu_size = (sz == 2'b00) ? 2'b10 : 2'b00;
      cpu_we = ~we;
      if (poke) begin
         map_wr = 1'b1; map_sparse_d = ~mode_m; be_swap = ~be_swap;
         mode_m = ~mode_m;
      end
      for (int k = 0; k < dly; k++) begin
         @(posedge clk); @(negedge clk);
         map_wr = 1'b0;
         chk(io_req && !cpu_ready && io_addr == ea && io_wdata == ew && io_size == sz && io_we == we,
             poke ? "R12" : "R10", {16'h0, io_addr}, {16'h0, ea});
      end
      cpu_req = 1'b0;
      io_ack = 1'b1; io_rdata = rd;
      @(posedge clk); @(negedge clk);
      io_ack = 1'b0; map_wr = 1'b0;
      chk(cpu_ready == 1'b1 && io_req == 1'b0, "R9", {30'h0, io_req, cpu_ready}, 32'h1);
      chk(cpu_rdata == conv(rd, sz, sw), poke ? "R12" : "R8", cpu_rdata, conv(rd, sz, sw));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cpu_ready == 1'b1 && io_req == 1'b0, "R1", {30'h0, io_req, cpu_ready}, 32'h1);
      chk(cpu_rdata == 32'h0, "R1", cpu_rdata, 32'h0);
      // R1: map-select resets to contiguous; R2 contiguous map
      run_txn(23'h7A_BCDE, 2'b00, 1'b1, 32'hDEAD_BE5A, 32'h1122_3344, 1, 0);
      // R7 unswapped halfword and word
      run_txn(23'h00_0061, 2'b01, 1'b0, 32'hCAFE_1234, 32'hAABB_CCDD, 0, 0);
      run_txn(23'h00_0400, 2'b10, 1'b1, 32'h0102_0304, 32'h5566_7788, 2, 0);
      // R5 / R6 swapped
      be_swap = 1'b1;
      run_txn(23'h00_03F8, 2'b01, 1'b1, 32'hFFFF_ABCD, 32'h9999_1357, 1, 0);
      run_txn(23'h00_0CF8, 2'b10, 1'b0, 32'h0102_0304, 32'h1020_3040, 3, 0);
      run_txn(23'h00_0092, 2'b00, 1'b0, 32'h1234_5678, 32'hFEDC_BA98, 0, 0);
      // R3 sparse map: switch with map_wr while idle
      map_wr = 1'b1; map_sparse_d = 1'b1; mode_m = 1'b1;
      @(negedge clk); map_wr = 1'b0;
      run_txn(23'h7F_F01F, 2'b10, 1'b1, 32'hA1B2_C3D4, 32'h0BAD_F00D, 1, 0);
      run_txn(23'h00_0FE0, 2'b01, 1'b0, 32'h0000_BEEF, 32'h0000_1234, 0, 0);
      run_txn(23'h55_5555, 2'b00, 1'b1, 32'h0000_00A5, 32'h0000_005A, 2, 0);
      // R12 flip mode and swap mid-flight
      run_txn(23'h12_3456, 2'b10, 1'b0, 32'h89AB_CDEF, 32'h0123_4567, 2, 1);
      run_txn(23'h6F_EDCB, 2'b01, 1'b1, 32'h0000_7766, 32'h0000_3322, 1, 1);
      // random mix
      for (int i = 0; i < 200; i++) begin
         logic [1:0] sz;
         sz = 2'($urandom_range(0, 2));
         be_swap = 1'($urandom);
         if (($urandom % 8) == 0) begin
            map_wr = 1'b1; map_sparse_d = 1'($urandom); mode_m = map_sparse_d;
            @(negedge clk); map_wr = 1'b0;
         end
         run_txn(23'($urandom), sz, 1'($urandom), $urandom, $urandom,
                 int'($urandom_range(0, 4)), (($urandom % 10) == 0));
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule